// File: doc/BRIEF.md
# Variable-Block Carry-Select Adder

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum with a carry-out, purely combinationally. The operand width is cut into blocks that widen toward the most significant end. The lowest block is an ordinary ripple adder fed by the real carry-in. Every higher block holds two ripple adders of its own width. One starts from an assumed incoming carry of 0 and the other from an assumed carry of 1. A 2-to-1 multiplexer, steered by the real carry leaving the block below, then keeps one of the two results.

The carry that crosses block boundaries passes through one multiplexer per block rather than through every bit. The wider upper blocks therefore have more time to settle their two candidates while the select carry climbs up through the narrower blocks below. Block widths come from a parameter list, lowest block first. Elaboration stops if the listed widths do not add up to the operand width.

The adder holds no state and has no handshake. A new operand pair may be presented at any time, and the result follows it without a clock.

Top module: `vbcsa_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout_o, sum_o} equals the 17-bit value a_i + b_i + cin_i.
- R2: Bit 0 forms its own block, driven directly by cin_i, so sum_o[0] equals a_i[0] XOR b_i[0] XOR cin_i.
- R3: With the default widths 6, 4, 3, 2 and 1 counted from the top, block boundaries fall below bits 1, 3, 6 and 10. A carry generated under any boundary reaches the block above it. For example, a_i = 2^k - 1, b_i = 0 and cin_i = 1 give sum_o = 2^k at each boundary bit k.
- R4: 0x7FFF + 0x0001 gives sum_o = 0x8000 and cout_o = 0 with cin_i = 0, and gives 0x8001 with cout_o = 0 with cin_i = 1.
- R5: 0xFFFF + 0x0001 gives sum_o = 0x0000 with cin_i = 0 and 0x0001 with cin_i = 1, with cout_o = 1 in both cases. 0xFFFF + 0x0000 with cin_i = 1 gives sum_o = 0x0000 and cout_o = 1.
- R6: The outputs depend only on the present inputs. A result is valid in the same cycle its operands are applied, and earlier operands have no effect on it.
- R7: With both operands zero, sum_o equals cin_i and cout_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of the top block |

## Verification
Every result of this adder is due zero cycles after its stimulus, since no register lies between the operand pins and the sum and carry pins. The bench changes operands just after a rising edge of its clock and compares both outputs half a period later, on the falling edge, before the next operand pair is applied. Because each vector is checked in the same cycle in which it was driven, no result can be credited to a previous vector. This also checks R6.

// File: rtl/vbcsa_pkg.sv
`timescale 1ns/1ps
package vbcsa_pkg;

  // Each block width occupies one fixed-size field of the packed list.
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned LIST_BITS = 256;

  typedef logic [LIST_BITS-1:0] blk_list_t;

  // Index of the two speculative candidates inside a select block.
  typedef enum logic {ASSUME_C0 = 1'b0, ASSUME_C1 = 1'b1} cand_e;

  function automatic int unsigned blk_width(input blk_list_t lst, input int unsigned idx);
    return 32'(lst[idx*FIELD_W +: FIELD_W]);
  endfunction

  // Bit position of the lowest bit of block idx.
  function automatic int unsigned blk_offset(input blk_list_t lst, input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < idx; k++) begin
      acc += 32'(lst[k*FIELD_W +: FIELD_W]);
    end
    return acc;
  endfunction

  function automatic int unsigned blk_total(input blk_list_t lst, input int unsigned count);
    return blk_offset(lst, count);
  endfunction

endpackage

// File: rtl/vbcsa_ripple.sv
`timescale 1ns/1ps
module vbcsa_ripple #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;

  assign chain[0] = c_i;

  // Generate/propagate per bit, then the carry recurrence.
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign gen[k]     = x_i[k] & y_i[k];
    assign prop[k]    = x_i[k] ^ y_i[k];
    assign s_o[k]     = prop[k] ^ chain[k];
    assign chain[k+1] = gen[k] | (prop[k] & chain[k]);
  end

  assign c_o = chain[WIDTH];

endmodule

// File: rtl/vbcsa_mux2.sv
`timescale 1ns/1ps
module vbcsa_mux2 #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] d0_i,
  input  logic [WIDTH-1:0] d1_i,
  input  logic             sel_i,
  output logic [WIDTH-1:0] q_o
);

  assign q_o = sel_i ? d1_i : d0_i;

endmodule

// File: rtl/vbcsa_select_blk.sv
`timescale 1ns/1ps
module vbcsa_select_blk
  import vbcsa_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             sel_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);

  localparam int unsigned PAIR_W = WIDTH + 1;

  logic [WIDTH-1:0]  cand_sum   [2];
  logic              cand_carry [2];
  logic [PAIR_W-1:0] cand_pair  [2];
  logic [PAIR_W-1:0] picked;

  // Two speculative adders, one per assumed incoming carry.
  for (genvar h = 0; h < 2; h++) begin : g_cand
    vbcsa_ripple #(.WIDTH(WIDTH)) u_cand (
      .x_i (x_i),
      .y_i (y_i),
      .c_i (h == int'(ASSUME_C1)),
      .s_o (cand_sum[h]),
      .c_o (cand_carry[h])
    );
    assign cand_pair[h] = {cand_carry[h], cand_sum[h]};
  end

  // The real carry from below picks sum and carry together.
  vbcsa_mux2 #(.WIDTH(PAIR_W)) u_pick (
    .d0_i  (cand_pair[0]),
    .d1_i  (cand_pair[1]),
    .sel_i (sel_i),
    .q_o   (picked)
  );

  assign s_o = picked[WIDTH-1:0];
  assign c_o = picked[WIDTH];

endmodule

// File: rtl/vbcsa_adder.sv
`timescale 1ns/1ps
module vbcsa_adder
  import vbcsa_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_BLK = 5,
  // Widths, lowest block in the lowest field.
  parameter logic [NUM_BLK*8-1:0] BLK_W_LIST = {8'd6, 8'd4, 8'd3, 8'd2, 8'd1}
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);

  localparam blk_list_t   LIST_EXT  = blk_list_t'(BLK_W_LIST);
  localparam int unsigned LIST_SUM  = blk_total(LIST_EXT, NUM_BLK);

  if (LIST_SUM != DATA_W) begin : g_bad_list
    $error("block widths add to %0d, operand width is %0d", LIST_SUM, DATA_W);
  end

  // blk_carry[n] is the real carry entering block n.
  logic [NUM_BLK:0] blk_carry;

  assign blk_carry[0] = cin_i;

  for (genvar n = 0; n < NUM_BLK; n++) begin : g_blk
    localparam int unsigned BW  = blk_width(LIST_EXT, n);
    localparam int unsigned OFS = blk_offset(LIST_EXT, n);

    if (n == 0) begin : g_base
      vbcsa_ripple #(.WIDTH(BW)) u_base (
        .x_i (a_i[OFS +: BW]),
        .y_i (b_i[OFS +: BW]),
        .c_i (blk_carry[n]),
        .s_o (sum_o[OFS +: BW]),
        .c_o (blk_carry[n+1])
      );
    end else begin : g_spec
      vbcsa_select_blk #(.WIDTH(BW)) u_sel (
        .x_i   (a_i[OFS +: BW]),
        .y_i   (b_i[OFS +: BW]),
        .sel_i (blk_carry[n]),
        .s_o   (sum_o[OFS +: BW]),
        .c_o   (blk_carry[n+1])
      );
    end
  end

  assign cout_o = blk_carry[NUM_BLK];

endmodule

// File: rtl/vbcsa_adder_chk.sv
`timescale 1ns/1ps
module vbcsa_adder_chk
  import vbcsa_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_BLK = 5,
  parameter logic [NUM_BLK*8-1:0] BLK_W_LIST = {8'd6, 8'd4, 8'd3, 8'd2, 8'd1}
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cin_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              cout_o,
  input logic [NUM_BLK:0]  blk_carry
);

  localparam blk_list_t LIST_EXT = blk_list_t'(BLK_W_LIST);

  logic [DATA_W:0] full_ref;
  assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r1_exact_sum: assert ({cout_o, sum_o} == full_ref)
        else $error("sum mismatch");
      a_r2_low_bit: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
        else $error("bit 0 mismatch");
      a_r7_zero_operands: assert (!((a_i == '0) && (b_i == '0)) ||
                                  ((sum_o == {{(DATA_W-1){1'b0}}, cin_i}) && !cout_o))
        else $error("zero operands mismatch");
      a_r5_wrap: assert (!((a_i == '1) && (b_i == '0) && cin_i) ||
                         ((sum_o == '0) && cout_o))
        else $error("wrap mismatch");
      // R3: the carry entering each block matches the true carry out of the bits below it.
      for (int unsigned n = 1; n < NUM_BLK; n++) begin
        a_r3_boundary_carry: assert (blk_carry[n] ==
            (((({1'b0, a_i} & (({{DATA_W{1'b0}}, 1'b1} << blk_offset(LIST_EXT, n)) - 1'b1)) +
               ({1'b0, b_i} & (({{DATA_W{1'b0}}, 1'b1} << blk_offset(LIST_EXT, n)) - 1'b1)) +
               {{DATA_W{1'b0}}, cin_i}) >> blk_offset(LIST_EXT, n)) != 0))
          else $error("boundary carry mismatch at block %0d", n);
      end
    end
  end

endmodule

bind vbcsa_adder vbcsa_adder_chk #(
  .DATA_W     (DATA_W),
  .NUM_BLK    (NUM_BLK),
  .BLK_W_LIST (BLK_W_LIST)
) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .blk_carry (blk_carry)
);

// File: tb/tb_vbcsa_adder.sv
`timescale 1ns/1ps
module tb_vbcsa_adder;

  localparam int unsigned W        = 16;
  localparam int unsigned N_RANDOM = 400;
  localparam int unsigned WDOG     = 200000;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  always #4 clk = ~clk;

  vbcsa_adder dut (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // Drive after a rising edge, compare on the following falling edge (R6).
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                       input string req);
    logic [W:0] exp_v;
    @(posedge clk);
    #1;
    a   = x;
    b   = y;
    cin = c;
    exp_v = ref_add(x, y, c);
    @(negedge clk);
    n_checks++;
    if ({cout, sum} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h expected cout=%b sum=%h",
               req, x, y, c, cout, sum, exp_v[W], exp_v[W-1:0]);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    int unsigned bounds [4] = '{1, 3, 6, 10};
    seed_dummy = $urandom(32'h5EED_0A11);

    // Reset-like starting state: zero operands (R7).
    apply(16'h0000, 16'h0000, 1'b0, "R7");
    apply(16'h0000, 16'h0000, 1'b1, "R7");

    // Bit 0 block with every input combination (R2).
    for (int i = 0; i < 8; i++) begin
      apply({15'h0, i[0]}, {15'h0, i[1]}, i[2], "R2");
    end

    // Carries across each block boundary (R3).
    foreach (bounds[j]) begin
      apply(W'((1 << bounds[j]) - 1), 16'h0000, 1'b1, "R3");
      apply(W'((1 << bounds[j]) - 1), 16'h0001, 1'b0, "R3");
      apply(W'(1 << (bounds[j] - 1)), W'(1 << (bounds[j] - 1)), 1'b0, "R3");
    end

    // Long ripples through every boundary (R4, R5).
    apply(16'h7FFF, 16'h0001, 1'b0, "R4");
    apply(16'h7FFF, 16'h0001, 1'b1, "R4");
    apply(16'hFFFF, 16'h0001, 1'b0, "R5");
    apply(16'hFFFF, 16'h0001, 1'b1, "R5");
    apply(16'hFFFF, 16'h0000, 1'b1, "R5");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R5");

    // Alternating patterns, then constrained random (R1).
    apply(16'hAAAA, 16'h5555, 1'b1, "R1");
    apply(16'h5555, 16'h5555, 1'b0, "R1");
    for (int i = 0; i < int'(N_RANDOM); i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (i % 4 == 0) rb = ~ra;
      apply(ra, rb, 1'($urandom), "R1");
    end

    // Result after a large vector is not affected by it (R6).
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    apply(16'h0001, 16'h0002, 1'b0, "R6");

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WDOG);
      report();
      $finish;
    end
  end

endmodule